// File: doc/BRIEF.md
# Exception Return Integrity Checker

This block decides whether a request to leave an exception handler is legitimate. A core presents the request when a handler branches to one of the special return values. The request carries the 32-bit return value, the current execution mode, the number of the exception that is ending, the bitmap of exceptions marked active, and the status word popped from the exception frame. The block compares the requested target mode with the active bitmap and with the exception-number field of that stacked status word.

One clock edge after the request, the block reports exactly one outcome. It either accepts the return, or raises an illegal-return usage fault, or, when the core was in thread mode, reports an instruction fetch from a never-executable address. An accepted return gives the target mode and a one-hot mask that clears the active bit of the finishing exception. Every rejected return sets a sticky flag in a fault status word. Software clears that flag by writing ones to it.

Top module: `exc_return_check`

## Requirements
- R1: In handler mode, a return value of 0xFFFFFFF1 is accepted when the returning exception's active bit is set and stacked status bits [8:0] are nonzero. The result has accept=1 and to_thread=0, and the clear mask has only the bit of the returning exception set.
- R2: In handler mode, a return value of 0xFFFFFFF9 is accepted when the returning exception is the only active one and stacked status bits [8:0] are zero. The result has accept=1, to_thread=1, and a one-hot clear mask for that exception.
- R3: Any return value other than 0xFFFFFFF1 or 0xFFFFFFF9, for example 0xFFFFFFF0, gives bad_ret=1.
- R4: A return whose exception has its bit clear in the active bitmap gives bad_ret=1.
- R5: A return to thread mode while any other exception is still active gives bad_ret=1.
- R6: A return to thread mode with nonzero stacked status bits [8:0] gives bad_ret=1.
- R7: A return to handler mode with zero stacked status bits [8:0] gives bad_ret=1.
- R8: Each bad_ret sets bit 18 of fault_status. A status write clears each bit of [31:16] that is written as 1. Bits [15:0] of the write are ignored. When a fault and a clear of bit 18 happen in the same cycle, the fault wins and the bit stays set.
- R9: A request made in thread mode is not a return. It gives fetch_viol=1, accept=0, bad_ret=0 and a zero clear mask, and it leaves fault_status unchanged.
- R10: Several checks failing together give one bad_ret result with a zero clear mask and to_thread=0.
- R11: Each request produces exactly one result one clock edge later, and back-to-back requests are supported. res_valid stays low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_retval | input | 32 | Branch target holding the return value |
| req_in_handler | input | 1 | 1 when the core is in handler mode |
| req_exc_num | input | 5 | Number of the exception that is returning |
| req_active | input | 32 | Bitmap of active exceptions |
| req_xpsr | input | 32 | Stacked status word from the frame |
| fsr_wr_valid | input | 1 | Fault status write strobe |
| fsr_wr_data | input | 32 | Write-one-to-clear data |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Return accepted |
| res_bad_ret | output | 1 | Illegal-return usage fault |
| res_fetch_viol | output | 1 | Never-executable fetch fault |
| res_to_thread | output | 1 | Accepted return goes to thread mode |
| res_clr_mask | output | 32 | Active bit to clear |
| fault_status | output | 32 | Sticky fault status word |

## Verification
A new illegal return and a software write that clears bit 18 can land on the same clock edge. To provoke this, the bench first leaves the flag set and then drives a failing request together with a status write of 0x00040000. The scoreboard expects the flag to stay set, both in the result record for that request and in a later read of the status. The bench also checks the opposite case: a write that arrives alone clears bit 18, while the bits of [15:0] in that write change nothing.

// File: rtl/exc_return_check.sv
module exc_return_check #(
  parameter int NUM_EXC     = 32,
  parameter int BAD_RET_BIT = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [31:0]                req_retval,
  input  logic                       req_in_handler,
  input  logic [$clog2(NUM_EXC)-1:0] req_exc_num,
  input  logic [NUM_EXC-1:0]         req_active,
  input  logic [31:0]                req_xpsr,
  input  logic                       fsr_wr_valid,
  input  logic [31:0]                fsr_wr_data,
  output logic                       res_valid,
  output logic                       res_accept,
  output logic                       res_bad_ret,
  output logic                       res_fetch_viol,
  output logic                       res_to_thread,
  output logic [NUM_EXC-1:0]         res_clr_mask,
  output logic [31:0]                fault_status
);
  localparam logic [31:0] RET_HANDLER = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_THREAD  = 32'hFFFF_FFF9;
  localparam logic [31:0] EXC_FIELD   = 32'h0000_01FF;
  localparam logic [31:0] W1C_MASK    = 32'hFFFF_0000;
  localparam logic [31:0] BAD_FLAG    = 32'(1) << BAD_RET_BIT;

  logic [NUM_EXC-1:0] own_bit;
  logic to_thread, known, inactive, others, field_zero, bad;
  logic is_ret, fetch, ok, flt;
  logic [31:0] clr_bits, fsr_next;

  assign own_bit    = NUM_EXC'(1) << req_exc_num;
  assign to_thread  = (req_retval == RET_THREAD);
  assign known      = to_thread || (req_retval == RET_HANDLER);
  assign inactive   = (req_active & own_bit) == '0;
  assign others     = (req_active & ~own_bit) != '0;
  assign field_zero = (req_xpsr & EXC_FIELD) == '0;

  assign bad = !known || inactive
             || ( to_thread && (others || !field_zero))
             || (!to_thread && field_zero);

  assign is_ret = req_valid &&  req_in_handler;
  assign fetch  = req_valid && !req_in_handler;
  assign ok     = is_ret && !bad;
  assign flt    = is_ret &&  bad;

  assign clr_bits = fsr_wr_valid ? (fsr_wr_data & W1C_MASK) : '0;
  assign fsr_next = (fault_status & ~clr_bits) | (flt ? BAD_FLAG : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_accept     <= 1'b0;
      res_bad_ret    <= 1'b0;
      res_fetch_viol <= 1'b0;
      res_to_thread  <= 1'b0;
      res_clr_mask   <= '0;
      fault_status   <= '0;
    end else begin
      res_valid      <= req_valid;
      res_accept     <= ok;
      res_bad_ret    <= flt;
      res_fetch_viol <= fetch;
      res_to_thread  <= ok && to_thread;
      res_clr_mask   <= ok ? own_bit : '0;
      fault_status   <= fsr_next;
    end
  end

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_accept, res_bad_ret, res_fetch_viol}));

  p_result_needs_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));

  p_request_gives_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  p_fault_flags_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_bad_ret |-> fault_status[BAD_RET_BIT]);

  p_accept_clears_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> $onehot(res_clr_mask));

  p_thread_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_accept && res_to_thread) |-> $onehot($past(req_active)));

  p_fetch_keeps_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fetch_viol && !$past(fsr_wr_valid)) |-> $stable(fault_status));
endmodule

// File: tb/exc_return_check_tb.sv
`timescale 1ns/1ps
module exc_return_check_tb;
  typedef struct packed {
    logic        acc;
    logic        bad;
    logic        fetch;
    logic        thr;
    logic [31:0] clr;
    logic [31:0] fsr;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_in_handler = 0, fsr_wr_valid = 0;
  logic [31:0] req_retval = 0, req_active = 0, req_xpsr = 0, fsr_wr_data = 0;
  logic [4:0] req_exc_num = 0;
  logic res_valid, res_accept, res_bad_ret, res_fetch_viol, res_to_thread;
  logic [31:0] res_clr_mask, fault_status;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t exp_q[$];
  string tag_q[$];
  logic [31:0] model_fsr = 0;

  always #2 clk = ~clk;

  exc_return_check u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_retval(req_retval),
    .req_in_handler(req_in_handler), .req_exc_num(req_exc_num),
    .req_active(req_active), .req_xpsr(req_xpsr), .fsr_wr_valid(fsr_wr_valid),
    .fsr_wr_data(fsr_wr_data), .res_valid(res_valid), .res_accept(res_accept),
    .res_bad_ret(res_bad_ret), .res_fetch_viol(res_fetch_viol),
    .res_to_thread(res_to_thread), .res_clr_mask(res_clr_mask),
    .fault_status(fault_status));

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [31:0] rv, logic inh, logic [4:0] exc,
                      logic [31:0] act, logic [31:0] xpsr,
                      logic wr = 0, logic [31:0] wdata = 0);
    item_t it;
    logic own_set, others, fz, thr, known, bad;
    @(negedge clk);
    req_valid = 1; req_retval = rv; req_in_handler = inh; req_exc_num = exc;
    req_active = act; req_xpsr = xpsr; fsr_wr_valid = wr; fsr_wr_data = wdata;
    own_set = act[exc];
    others  = (act & ~(32'd1 << exc)) != 0;
    fz      = xpsr[8:0] == 0;
    thr     = rv == 32'hFFFF_FFF9;
    known   = thr || rv == 32'hFFFF_FFF1;
    bad     = !known || !own_set || (thr && (others || !fz)) || (!thr && fz);
    it = '0;
    if (!inh) it.fetch = 1;
    else if (bad) it.bad = 1;
    else begin it.acc = 1; it.thr = thr; it.clr = 32'd1 << exc; end
    if (wr) model_fsr = model_fsr & ~(wdata & 32'hFFFF_0000);
    if (it.bad) model_fsr = model_fsr | 32'h0004_0000;
    it.fsr = model_fsr;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic quiet();
    @(negedge clk);
    req_valid = 0; fsr_wr_valid = 0;
  endtask

  task automatic clear_status(string tag, logic [31:0] wdata);
    @(negedge clk);
    req_valid = 0; fsr_wr_valid = 1; fsr_wr_data = wdata;
    model_fsr = model_fsr & ~(wdata & 32'hFFFF_0000);
    @(negedge clk);
    fsr_wr_valid = 0;
    check(tag, {64'd0, fault_status}, {64'd0, model_fsr});
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected result: actual valid=1 expected valid=0");
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {28'd0, res_accept, res_bad_ret, res_fetch_viol, res_to_thread,
                  res_clr_mask, fault_status}, {28'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset", {31'd0, res_valid, res_clr_mask, fault_status}, 96'd0);

    send("R1 handler return", 32'hFFFF_FFF1, 1, 5'd15, 32'h0000_8800, 32'h0100_000B); quiet();
    send("R2 thread return", 32'hFFFF_FFF9, 1, 5'd11, 32'h0000_0800, 32'h0100_0000); quiet();
    send("R3 reserved F0", 32'hFFFF_FFF0, 1, 5'd11, 32'h0000_0800, 32'h0100_0000); quiet();
    send("R3 reserved FD", 32'hFFFF_FFFD, 1, 5'd11, 32'h0000_0800, 32'h0100_0000); quiet();
    clear_status("R8 low half ignored", 32'h0000_FFFF);
    clear_status("R8 w1c clears", 32'h0004_0000);

    send("R4 inactive", 32'hFFFF_FFF1, 1, 5'd11, 32'h0000_8000, 32'h0100_000B); quiet();
    clear_status("R8 clear after R4", 32'hFFFF_0000);
    send("R5 nested to thread", 32'hFFFF_FFF9, 1, 5'd11, 32'h0000_8800, 32'h0100_0000); quiet();
    send("R6 thread nonzero field", 32'hFFFF_FFF9, 1, 5'd11, 32'h0000_0800, 32'h0100_0003); quiet();
    send("R7 handler zero field", 32'hFFFF_FFF1, 1, 5'd11, 32'h0000_8800, 32'h0100_0000); quiet();
    clear_status("R8 clear after R7", 32'h0004_0000);

    send("R9 thread mode F9", 32'hFFFF_FFF9, 0, 5'd0, 32'h0, 32'h0100_0000); quiet();
    send("R9 thread mode F1", 32'hFFFF_FFF1, 0, 5'd3, 32'h0000_0008, 32'h0100_0003); quiet();
    send("R10 multiple failures", 32'hFFFF_FFF9, 1, 5'd11, 32'h0000_8000, 32'h0100_0010); quiet();
    send("R8 fault beats clear", 32'hFFFF_FFF0, 1, 5'd11, 32'h0000_0800, 32'h0, 1, 32'h0004_0000); quiet();
    @(negedge clk);
    check("R8 flag held", {64'd0, fault_status}, {64'd0, 32'h0004_0000});
    clear_status("R8 final clear", 32'h0004_0000);

    send("R11 back-to-back a", 32'hFFFF_FFF1, 1, 5'd15, 32'h0000_8800, 32'h0000_000F);
    send("R11 back-to-back b", 32'hFFFF_FFF1, 1, 5'd2,  32'h0000_8800, 32'h0000_000F);
    send("R11 back-to-back c", 32'hFFFF_FFF9, 1, 5'd31, 32'h8000_0000, 32'h0000_0000);
    quiet();
    repeat (3) @(negedge clk);
    check("R11 idle", {95'd0, res_valid}, 96'd0);
    check("R11 all results seen", 96'(exp_q.size()), 96'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule